// File: doc/BRIEF.md
# 4B/5B Transmit Code-Group Encoder

This block sits on the transmit side of a 100 Mb/s twisted-pair path, between the MAC-side nibble interface and the serializer. On every nibble slot, marked by a one-cycle slot enable, it samples a 4-bit nibble and a transmit-enable. One clock later it presents one registered 5-bit code-group together with a one-cycle strobe.

A frame opens when transmit-enable rises. The block sends the start delimiter pair J then K in place of the first two preamble nibbles. It then maps every later preamble and data nibble through the fixed 4B/5B data table. When transmit-enable falls, it sends the end delimiter pair T then R. After that it fills every slot with IDLE until the next frame begins. A delimiter pair that has started is always sent in full. If a new frame begins during R, the start pair follows at once, and the nibbles that arrive during R, J and K take the place of the replaced preamble.

Top module: `tx4b5b_encoder`

## Requirements
- R1: During and right after reset, the code-group output is 11111 and the strobe is low.
- R2: The strobe is high for exactly the clock that follows a slot enable, and is low at all other times. The code-group output changes only on that clock. Nibble and transmit-enable values between slots have no effect.
- R3: On a slot with transmit-enable low while no frame is active, the block sends IDLE = 11111.
- R4: On the first slot with transmit-enable high while idle, the block sends J = 11000. On the next slot it sends K = 10001. The nibbles sampled on these two slots are discarded.
- R5: After K, each slot with transmit-enable high sends the code for the sampled nibble: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: The first slot after K with transmit-enable low sends T = 01101. The next slot sends R = 00111. If transmit-enable is low on that R slot, IDLE follows.
- R7: If transmit-enable is high on the R slot, R is still sent. J follows on the next slot and K on the slot after. The nibbles of the R, J and K slots are discarded, and mapping resumes on the slot after K.
- R8: If transmit-enable falls on the J or K slot, the start pair is still completed. T and R then follow on the next two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_en | input | 1 | Nibble slot enable, one clock per slot |
| tx_en | input | 1 | Transmit-enable from the MAC side |
| tx_nib | input | 4 | Transmit nibble |
| cg_q | output | 5 | Registered code-group |
| cg_vld | output | 1 | Strobe, high for the clock after each slot |

## Verification
A wrong framing state shows up on the very next strobe. A missing or doubled K, an R followed by IDLE when a new frame has already begun, or a data code where T belongs is all visible one slot after the bad transition. A lost transition also shifts every later code-group of the frame. The bench checks every strobe, so the error is caught within one slot. A fault in the data table shows on the first slot that carries the affected nibble. Directed sweeps cover all sixteen values, so such a fault is found in the first frame.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [CG_W-1:0]  cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;

  // ST_J is only reached when a frame restarts during R
  typedef enum logic [2:0] {ST_IDLE, ST_J, ST_K, ST_DATA, ST_R} st_e;
  typedef enum logic [2:0] {SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_T, SEL_R} sel_e;

  function automatic cg_t enc_nibble(nib_t n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  function automatic cg_t ctrl_code(sel_e s);
    case (s)
      SEL_J:   return CG_J;
      SEL_K:   return CG_K;
      SEL_T:   return CG_T;
      SEL_R:   return CG_R;
      default: return CG_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/tx4b5b_datamap.sv
module tx4b5b_datamap
  import tx4b5b_pkg::*;
(
  input  nib_t nib,
  output cg_t  cg
);
  assign cg = enc_nibble(nib);
endmodule

// File: rtl/tx4b5b_ctrl.sv
module tx4b5b_ctrl
  import tx4b5b_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot,
  input  logic tx_en,
  output st_e  state_q,
  output sel_e sel,
  output logic ev_sof,
  output logic ev_eof
);
  st_e nxt;

  always_comb begin
    nxt = state_q;
    sel = SEL_IDLE;
    case (state_q)
      ST_IDLE: if (tx_en) begin sel = SEL_J; nxt = ST_K; end
      ST_J:    begin sel = SEL_J; nxt = ST_K; end
      ST_K:    begin sel = SEL_K; nxt = ST_DATA; end
      ST_DATA: begin
        if (tx_en) sel = SEL_DATA;
        else begin sel = SEL_T; nxt = ST_R; end
      end
      ST_R:    begin sel = SEL_R; nxt = tx_en ? ST_J : ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= ST_IDLE;
    else if (slot) state_q <= nxt;
  end

  assign ev_sof = slot && (sel == SEL_J);
  assign ev_eof = slot && (sel == SEL_T);
endmodule

// File: rtl/tx4b5b_outreg.sv
module tx4b5b_outreg
  import tx4b5b_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot,
  input  sel_e sel,
  input  cg_t  data_cg,
  output cg_t  cg_q,
  output logic cg_vld
);
  cg_t pick;
  assign pick = (sel == SEL_DATA) ? data_cg : ctrl_code(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cg_q   <= CG_IDLE;
      cg_vld <= 1'b0;
    end else begin
      cg_vld <= slot;
      if (slot) cg_q <= pick;
    end
  end
endmodule

// File: rtl/tx4b5b_encoder.sv
module tx4b5b_encoder
  import tx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_en,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] tx_nib,
  output logic [CG_W-1:0]  cg_q,
  output logic             cg_vld
);
  st_e  st_w;
  sel_e sel_w;
  cg_t  data_cg_w;
  logic ev_sof_w;
  logic ev_eof_w;

  tx4b5b_datamap u_map (.nib(tx_nib), .cg(data_cg_w));

  tx4b5b_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .slot(nib_en), .tx_en(tx_en),
    .state_q(st_w), .sel(sel_w), .ev_sof(ev_sof_w), .ev_eof(ev_eof_w)
  );

  tx4b5b_outreg u_out (
    .clk(clk), .rst_n(rst_n), .slot(nib_en), .sel(sel_w),
    .data_cg(data_cg_w), .cg_q(cg_q), .cg_vld(cg_vld)
  );
endmodule

// File: rtl/tx4b5b_chk.sv
module tx4b5b_chk
  import tx4b5b_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic nib_en,
  input logic tx_en,
  input nib_t tx_nib,
  input cg_t  cg_q,
  input logic cg_vld,
  input st_e  state_q,
  input logic ev_sof,
  input logic ev_eof
);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_en |=> $stable(cg_q) && !cg_vld);
  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en |=> cg_vld);
  assert_idle_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en && state_q == ST_IDLE && !tx_en |=> cg_q == CG_IDLE);
  assert_start_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> cg_q == CG_J && state_q == ST_K);
  assert_data_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en && state_q == ST_DATA && tx_en |=> cg_q == enc_nibble($past(tx_nib)));
  assert_end_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eof |=> cg_q == CG_T && state_q == ST_R);
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en && state_q == ST_R && tx_en |=> cg_q == CG_R && state_q == ST_J);
  assert_k_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nib_en && state_q == ST_K |=> cg_q == CG_K && state_q == ST_DATA);
endmodule

bind tx4b5b_encoder tx4b5b_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .tx_en(tx_en), .tx_nib(tx_nib),
  .cg_q(cg_q), .cg_vld(cg_vld), .state_q(st_w), .ev_sof(ev_sof_w), .ev_eof(ev_eof_w)
);

// File: tb/tx4b5b_encoder_tb.sv
module tx4b5b_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nib_en = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [4:0] cg_q;
  logic       cg_vld;

  int checks = 0;
  int errors = 0;
  int ph = 0;          // 0 idle, 1 K due, 2 data, 3 R due, 4 J due
  logic [4:0] last_cg = 5'b11111;
  int unsigned seed_dummy;

  localparam logic [79:0] TABLE = {5'b11101, 5'b11100, 5'b11011, 5'b11010,
                                   5'b10111, 5'b10110, 5'b10011, 5'b10010,
                                   5'b01111, 5'b01110, 5'b01011, 5'b01010,
                                   5'b10101, 5'b10100, 5'b01001, 5'b11110};

  always #2 clk = ~clk;

  tx4b5b_encoder u_dut (.clk(clk), .rst_n(rst_n), .nib_en(nib_en), .tx_en(tx_en),
                        .tx_nib(tx_nib), .cg_q(cg_q), .cg_vld(cg_vld));

  function automatic logic [4:0] code_of(logic [3:0] n);
    return TABLE[n*5 +: 5];
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // expected code-group for one slot; advances the bench model
  function automatic logic [4:0] model(logic t, logic [3:0] n, output string req);
    logic [4:0] e;
    case (ph)
      0: begin if (t) begin e = 5'b11000; ph = 1; req = "R4"; end
               else begin e = 5'b11111; req = "R3"; end end
      1: begin e = 5'b10001; ph = 2; req = "R4"; end
      2: begin if (t) begin e = code_of(n); req = "R5"; end
               else begin e = 5'b01101; ph = 3; req = "R6"; end end
      3: begin e = 5'b00111; ph = t ? 4 : 0; req = "R6"; end
      default: begin e = 5'b11000; ph = 1; req = "R7"; end
    endcase
    return e;
  endfunction

  task automatic slot(logic t, logic [3:0] n, int gap, string tag = "");
    string req;
    logic [4:0] e;
    @(negedge clk);
    tx_en = t; tx_nib = n; nib_en = 1'b1;
    e = model(t, n, req);
    if (tag != "") req = tag;
    @(negedge clk);
    nib_en = 1'b0;
    check({req, " code"}, {1'b1, cg_q}, {1'b1, e});
    check("R2 strobe", {5'b0, cg_vld}, 6'd1);
    last_cg = e;
    for (int i = 0; i < gap; i++) begin
      tx_en = 1'($urandom); tx_nib = 4'($urandom);
      @(negedge clk);
      check("R2 hold", {cg_vld, cg_q}, {1'b0, last_cg});
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h4b5b_0001);
    repeat (3) @(negedge clk);
    check("R1 reset", {cg_vld, cg_q}, {1'b0, 5'b11111});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {cg_vld, cg_q}, {1'b0, 5'b11111});

    // R3 idle fill, with garbage nibbles
    slot(0, 4'h5, 1, "R3"); slot(0, 4'hA, 0, "R3");
    // R4/R5: start, preamble, all 16 values
    slot(1, 4'h5, 2, "R4"); slot(1, 4'h5, 0, "R4");
    for (int v = 0; v < 16; v++) slot(1, 4'(v), v % 3, "R5");
    // R6 end pair, then idle
    slot(0, 4'h3, 1, "R6"); slot(0, 4'h3, 0, "R6"); slot(0, 4'h3, 0, "R3");
    // R7 restart during R
    slot(1, 4'h5, 0, "R4"); slot(1, 4'h5, 0, "R4"); slot(1, 4'h9, 0, "R5");
    slot(0, 4'h0, 0, "R6"); slot(1, 4'h5, 0, "R7");
    slot(1, 4'h5, 0, "R7"); slot(1, 4'h5, 0, "R7"); slot(1, 4'hD, 1, "R7");
    // R8 drop during K from idle start
    slot(0, 4'h0, 0, "R6"); slot(0, 4'h0, 0, "R6");
    slot(1, 4'h5, 0, "R4"); slot(0, 4'h5, 0, "R8"); slot(0, 4'h5, 0, "R8");
    slot(0, 4'h5, 0, "R8"); slot(0, 4'h5, 0, "R3");
    // R8 drop during restarted J
    slot(1, 4'h5, 0, "R4"); slot(1, 4'h5, 0, "R4"); slot(0, 4'h5, 0, "R6");
    slot(1, 4'h5, 0, "R7"); slot(0, 4'h5, 0, "R8"); slot(0, 4'h5, 0, "R8");
    slot(0, 4'h5, 0, "R8"); slot(0, 4'h5, 0, "R8"); slot(0, 4'h5, 0, "R3");

    // constrained random frames
    begin
      logic t = 1'b0;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(7) == 0) t = ~t;
        slot(t, 4'($urandom), int'($urandom_range(2)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule